// File: doc/BRIEF.md
# Passive Configuration Loader for SRAM-Based Programmable Logic

This block sits on the host side of a programmable device whose configuration memory is volatile and must be reloaded after every power-up or on demand. A start pulse makes it hold the target's active-low configuration request for a minimum time and then release it. The block then waits until the target's open-drain status line reads high. Once it does, the block takes bitstream bytes from a local valid/ready stream and drives them onto the target's data lines. It produces a configuration clock, and the target latches data on each rising edge of that clock.

A parameter selects the data path. In serial mode the block sends one bit per clock on a single line, least-significant bit first. In parallel mode it sends one whole byte per clock on an 8-bit bus. When the target's done line rises, the block keeps clocking for extra initialization cycles. These end either when the target's init-done input reads high or after a fixed count, as chosen by a parameter. The block then parks the clock low and drives the data lines high.

The block also handles failures. If the status line drops in the middle of the data phase, the block flags the fault and restarts from the reset stage. If the stream ends before done rises, or if status never goes high, the block stops with an error code.

Top module: `pscfg_host`

## Requirements
- R1: While reset is applied, and after it until a start pulse arrives, the configuration request output is low, the configuration clock is low, every data line is high, and `s_ready_o`, `busy_o`, `ok_o` and `err_o` are low.
- R2: A start pulse, sampled when the block is not busy, drives the configuration request low for exactly `RESET_LOW_CYC` system cycles and then high. No byte is accepted and the clock stays low until the status input reads high. A start pulse sampled while `busy_o` is high has no effect.
- R3: In the data phase, each configuration clock high phase lasts exactly `CLK_DIV` system cycles, and each low phase lasts at least `CLK_DIV` cycles. The data lines change only while the clock is low, so they are stable at every rising edge.
- R4: In serial mode (`PAR_MODE`=0), each accepted byte goes out on `tgt_data_o[0]` over 8 clock rising edges, bit 0 first.
- R5: In parallel mode (`PAR_MODE`=1), each accepted byte appears whole on `tgt_data_o[7:0]` for exactly one rising edge.
- R6: If the done input is high when the last beat of a byte ends (at the falling clock edge), the block moves to initialization. It accepts no further byte, even if one is offered.
- R7: During initialization the clock keeps toggling. With `USE_INIT_DONE`=0 it gives exactly `INIT_CLKS` rising edges. With `USE_INIT_DONE`=1 it stops after the falling edge at which the init-done input reads high.
- R8: If the status input reads low while the block is waiting for a byte or shifting one, then on the next cycle the request output is low, `err_o` is 1 and `err_code_o` is 3. The block then repeats the whole sequence. A later successful load clears `err_o` and sets `err_code_o` to 0.
- R9: If the byte marked last finishes while done is low, the block stops with `busy_o` low, `err_o` high and `err_code_o` equal to 2.
- R10: If status has not read high within `STAT_TIMEOUT` cycles after the request goes high, the block stops with `busy_o` low, `err_o` high and `err_code_o` equal to 1.
- R11: After a successful load, `ok_o` is high, `busy_o` and `err_o` are low, the clock is low and every data line is high. A new start pulse drives the request low again, which begins a reconfiguration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins a (re)configuration |
| s_valid_i | input | 1 | Bitstream byte valid |
| s_data_i | input | 8 | Bitstream byte |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Block accepts the byte this cycle |
| tgt_cfg_n_o | output | 1 | Active-low configuration request to the target |
| tgt_status_i | input | 1 | Target open-drain status line, read level |
| tgt_done_i | input | 1 | Target done line |
| tgt_initdone_i | input | 1 | Target init-done line (used when `USE_INIT_DONE`=1) |
| tgt_clk_o | output | 1 | Configuration clock |
| tgt_data_o | output | 1 or 8 | Configuration data (8 bits when `PAR_MODE`=1) |
| busy_o | output | 1 | A configuration sequence is in progress |
| ok_o | output | 1 | Target loaded and initialized |
| err_o | output | 1 | Last sequence hit an error |
| err_code_o | output | 2 | 0 none, 1 status timeout, 2 stream ended without done, 3 status dropped |

## Verification
Two events can fall in the same cycle. The target can pull status low in the very cycle that the block accepts a byte or ends a bit, and the drop must take priority: the request goes low on the next cycle and no byte is consumed. The bench provokes this by dropping status partway through the second byte of a serial load. It then checks that the request falls one cycle later with error code 3, and that a full reload afterwards clears the error. A second collision is a byte offered by the stream at the same moment that done is seen. The bench keeps a third byte valid while done rises after the second byte, and it judges the result by confirming that ready never goes high and that initialization still completes.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_WSTAT,
      ST_LOAD,
      ST_SHIFT,
      ST_INIT,
      ST_USER,
      ST_ERR
   } cfg_state_e;

   typedef enum logic [1:0] {
      EC_NONE     = 2'd0,
      EC_TIMEOUT  = 2'd1,
      EC_NODONE   = 2'd2,
      EC_STATDROP = 2'd3
   } err_code_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pscfg_tick.sv
module pscfg_tick #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);
   localparam int unsigned CW = $clog2(DIV + 1);

   logic [CW-1:0] cnt_q;

   generate
      if (DIV == 1) begin : g_every
         assign tick_o = en_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= '0;
         end
      end else begin : g_count
         assign tick_o = en_i && (cnt_q == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (!en_i || tick_o)  cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/pscfg_shift.sv
module pscfg_shift #(
   parameter int unsigned BUS_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [7:0]       byte_i,
   input  logic             adv_i,
   output logic [BUS_W-1:0] data_o,
   output logic             last_beat_o
);
   logic [7:0] sh_q;

   generate
      if (BUS_W == 1) begin : g_serial
         logic [2:0] beat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q   <= '1;
               beat_q <= '0;
            end else if (load_i) begin
               sh_q   <= byte_i;
               beat_q <= '0;
            end else if (adv_i) begin
               sh_q   <= {1'b1, sh_q[7:1]};
               beat_q <= beat_q + 1'b1;
            end
         end
         assign data_o      = sh_q[0];
         assign last_beat_o = (beat_q == 3'd7);
      end else begin : g_parallel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sh_q <= '1;
            else if (load_i) sh_q <= byte_i;
         end
         assign data_o      = sh_q;
         assign last_beat_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pscfg_host.sv
module pscfg_host
   import pscfg_pkg::*;
#(
   parameter bit          PAR_MODE      = 1'b0,
   parameter int unsigned CLK_DIV       = 2,
   parameter int unsigned RESET_LOW_CYC = 5,
   parameter int unsigned STAT_TIMEOUT  = 40,
   parameter int unsigned INIT_CLKS     = 6,
   parameter bit          USE_INIT_DONE = 1'b0,
   localparam int unsigned BUS_W        = PAR_MODE ? 8 : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             s_valid_i,
   input  logic [7:0]       s_data_i,
   input  logic             s_last_i,
   output logic             s_ready_o,
   output logic             tgt_cfg_n_o,
   input  logic             tgt_status_i,
   input  logic             tgt_done_i,
   input  logic             tgt_initdone_i,
   output logic             tgt_clk_o,
   output logic [BUS_W-1:0] tgt_data_o,
   output logic             busy_o,
   output logic             ok_o,
   output logic             err_o,
   output logic [1:0]       err_code_o
);
   localparam int unsigned CNT_MAX = max3(RESET_LOW_CYC, STAT_TIMEOUT, INIT_CLKS);
   localparam int unsigned CW      = $clog2(CNT_MAX + 1);

   generate
      if (CLK_DIV < 1)       begin : g_bad_div   $error("CLK_DIV must be at least 1");       end
      if (RESET_LOW_CYC < 1) begin : g_bad_low   $error("RESET_LOW_CYC must be at least 1"); end
      if (STAT_TIMEOUT < 1)  begin : g_bad_to    $error("STAT_TIMEOUT must be at least 1");  end
      if (INIT_CLKS < 1)     begin : g_bad_init  $error("INIT_CLKS must be at least 1");     end
   endgenerate

   cfg_state_e       state_q;
   logic [CW-1:0]    cnt_q;
   logic             clk_q;
   logic             last_q;
   logic             err_q;
   err_code_e        code_q;

   logic             tick;
   logic             take;
   logic             adv;
   logic             last_beat;
   logic             init_fin;
   logic             in_data;
   logic [BUS_W-1:0] sh_data;

   assign in_data = (state_q == ST_LOAD) || (state_q == ST_SHIFT);
   assign take    = s_ready_o && s_valid_i;
   assign adv     = (state_q == ST_SHIFT) && tick && clk_q && tgt_status_i;

   pscfg_tick #(.DIV(CLK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   ((state_q == ST_SHIFT) || (state_q == ST_INIT)),
      .tick_o (tick)
   );

   pscfg_shift #(.BUS_W(BUS_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (take),
      .byte_i      (s_data_i),
      .adv_i       (adv),
      .data_o      (sh_data),
      .last_beat_o (last_beat)
   );

   generate
      if (USE_INIT_DONE) begin : g_init_pin
         assign init_fin = tgt_initdone_i;
      end else begin : g_init_cnt
         assign init_fin = (cnt_q == CW'(INIT_CLKS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         clk_q   <= 1'b0;
         last_q  <= 1'b0;
         err_q   <= 1'b0;
         code_q  <= EC_NONE;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_USER, ST_ERR: begin
               if (start_i) begin
                  state_q <= ST_RST;
                  cnt_q   <= '0;
                  clk_q   <= 1'b0;
                  err_q   <= 1'b0;
                  code_q  <= EC_NONE;
               end
            end
            ST_RST: begin
               if (cnt_q == CW'(RESET_LOW_CYC - 1)) begin
                  state_q <= ST_WSTAT;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_WSTAT: begin
               if (tgt_status_i) begin
                  state_q <= ST_LOAD;
                  cnt_q   <= '0;
               end else if (cnt_q == CW'(STAT_TIMEOUT - 1)) begin
                  state_q <= ST_ERR;
                  err_q   <= 1'b1;
                  code_q  <= EC_TIMEOUT;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_LOAD, ST_SHIFT: begin
               if (!tgt_status_i) begin
                  state_q <= ST_RST;
                  cnt_q   <= '0;
                  clk_q   <= 1'b0;
                  err_q   <= 1'b1;
                  code_q  <= EC_STATDROP;
               end else if (state_q == ST_LOAD) begin
                  if (s_valid_i) begin
                     state_q <= ST_SHIFT;
                     last_q  <= s_last_i;
                  end
               end else if (tick) begin
                  if (!clk_q) begin
                     clk_q <= 1'b1;
                  end else begin
                     clk_q <= 1'b0;
                     if (last_beat) begin
                        if (tgt_done_i) begin
                           state_q <= ST_INIT;
                           cnt_q   <= '0;
                        end else if (last_q) begin
                           state_q <= ST_ERR;
                           err_q   <= 1'b1;
                           code_q  <= EC_NODONE;
                        end else begin
                           state_q <= ST_LOAD;
                        end
                     end
                  end
               end
            end
            ST_INIT: begin
               if (tick) begin
                  if (!clk_q) begin
                     clk_q <= 1'b1;
                  end else begin
                     clk_q <= 1'b0;
                     cnt_q <= cnt_q + 1'b1;
                     if (init_fin) begin
                        state_q <= ST_USER;
                        err_q   <= 1'b0;
                        code_q  <= EC_NONE;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tgt_cfg_n_o = !((state_q == ST_IDLE) || (state_q == ST_RST));
   assign s_ready_o   = (state_q == ST_LOAD) && tgt_status_i;
   assign tgt_clk_o   = clk_q;
   assign tgt_data_o  = (state_q == ST_SHIFT) ? sh_data : {BUS_W{1'b1}};
   assign busy_o      = (state_q == ST_RST) || (state_q == ST_WSTAT) || in_data ||
                        (state_q == ST_INIT);
   assign ok_o        = (state_q == ST_USER);
   assign err_o       = err_q;
   assign err_code_o  = code_q;

   AST_DATA_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tgt_clk_o) |-> $stable(tgt_data_o)); // R3
   AST_NO_TAKE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> !tgt_clk_o); // R3
   AST_CLK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_clk_o |-> tgt_cfg_n_o); // R2
   AST_DROP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !tgt_status_i) |=> (!tgt_cfg_n_o && err_o && err_code_o == 2'd3)); // R8
   AST_USER_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |-> (!tgt_clk_o && (&tgt_data_o) && !busy_o && !err_o)); // R11
   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !busy_o) |-> (err_code_o != 2'd0)); // R9

endmodule

// File: tb/pscfg_host_bench.sv
`timescale 1ns/100ps
module pscfg_host_bench;
   localparam int DIV  = 2;
   localparam int LOWC = 5;
   localparam int STO  = 40;
   localparam int INIC = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // serial instance
   logic       start_a = 0, val_a = 0, last_a = 0;
   logic [7:0] dat_a = 0;
   logic       rdy_a, cfg_a, tclk_a, busy_a, ok_a, err_a;
   logic [0:0] tdat_a;
   logic [1:0] code_a;
   logic       rel_a = 0, done_a = 0;
   wire        stat_a = cfg_a & rel_a;

   pscfg_host #(.PAR_MODE(1'b0), .CLK_DIV(DIV), .RESET_LOW_CYC(LOWC),
                .STAT_TIMEOUT(STO), .INIT_CLKS(INIC), .USE_INIT_DONE(1'b0)) u_pscfg_host (
      .clk(clk), .rst_n(rst_n), .start_i(start_a), .s_valid_i(val_a), .s_data_i(dat_a),
      .s_last_i(last_a), .s_ready_o(rdy_a), .tgt_cfg_n_o(cfg_a), .tgt_status_i(stat_a),
      .tgt_done_i(done_a), .tgt_initdone_i(1'b0), .tgt_clk_o(tclk_a), .tgt_data_o(tdat_a),
      .busy_o(busy_a), .ok_o(ok_a), .err_o(err_a), .err_code_o(code_a));

   // parallel instance
   logic       start_b = 0, val_b = 0, last_b = 0;
   logic [7:0] dat_b = 0;
   logic       rdy_b, cfg_b, tclk_b, busy_b, ok_b, err_b;
   logic [7:0] tdat_b;
   logic [1:0] code_b;
   logic       rel_b = 0, done_b = 0, idone_b = 0;
   wire        stat_b = cfg_b & rel_b;

   pscfg_host #(.PAR_MODE(1'b1), .CLK_DIV(DIV), .RESET_LOW_CYC(LOWC),
                .STAT_TIMEOUT(STO), .INIT_CLKS(INIC), .USE_INIT_DONE(1'b1)) u_pscfg_host_par (
      .clk(clk), .rst_n(rst_n), .start_i(start_b), .s_valid_i(val_b), .s_data_i(dat_b),
      .s_last_i(last_b), .s_ready_o(rdy_b), .tgt_cfg_n_o(cfg_b), .tgt_status_i(stat_b),
      .tgt_done_i(done_b), .tgt_initdone_i(idone_b), .tgt_clk_o(tclk_b), .tgt_data_o(tdat_b),
      .busy_o(busy_b), .ok_o(ok_b), .err_o(err_b), .err_code_o(code_b));

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // target models, sampled between clock edges
   int   bits_a = 0, tgt_a = 32, init_a = 0, hi_a = 0;
   logic prev_a = 0;
   logic [0:0] pdat_a = 1;
   logic [7:0] rx_a [0:15];
   bit   seen_rdy_a = 0;
   int   bits_b = 0, tgt_b = 3, init_b = 0;
   logic prev_b = 0;
   logic [7:0] rx_b [0:7];

   always @(negedge clk) begin
      if (rdy_a) seen_rdy_a = 1'b1;
      if (!cfg_a) begin
         bits_a = 0; init_a = 0; done_a = 0; hi_a = 0;
      end else begin
         if (tclk_a && prev_a && tdat_a != pdat_a)
            chk(1'b0, "R3 data moved while clock high", int'(tdat_a), int'(pdat_a));
         if (tclk_a) hi_a++;
         if (!tclk_a && prev_a) begin
            if (stat_a) chk(hi_a == DIV, "R3 high phase", hi_a, DIV);
            hi_a = 0;
         end
         if (tclk_a && !prev_a) begin
            if (done_a) init_a++;
            else begin
               if (bits_a < 128) rx_a[bits_a/8][bits_a%8] = tdat_a[0];
               bits_a++;
            end
         end
         done_a = (bits_a >= tgt_a);
      end
      prev_a = tclk_a;
      pdat_a = tdat_a;
   end

   always @(negedge clk) begin
      if (!cfg_b) begin
         bits_b = 0; init_b = 0; done_b = 0; idone_b = 0;
      end else if (tclk_b && !prev_b) begin
         if (done_b) init_b++;
         else begin
            if (bits_b < 8) rx_b[bits_b] = tdat_b;
            bits_b++;
         end
         done_b  = (bits_b >= tgt_b);
         idone_b = (init_b >= 4);
      end
      prev_b = tclk_b;
   end

   task automatic send_a(input logic [7:0] d, input bit l);
      val_a = 1; dat_a = d; last_a = l;
      while (!rdy_a) @(negedge clk);
      @(negedge clk);
      val_a = 0; last_a = 0;
   endtask

   task automatic send_b(input logic [7:0] d, input bit l);
      val_b = 1; dat_b = d; last_b = l;
      while (!rdy_b) @(negedge clk);
      @(negedge clk);
      val_b = 0; last_b = 0;
   endtask

   task automatic pulse_a();
      start_a = 1; @(negedge clk); start_a = 0;
   endtask

   task automatic wait_a_idle(input int lim);
      for (int i = 0; i < lim && busy_a; i++) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5ns * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
   end

   logic [7:0] tx [0:3];
   logic [7:0] txb [0:2];
   int lowrun;

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(cfg_a == 0 && tclk_a == 0 && tdat_a == 1'b1, "R1 target lines", {cfg_a, tclk_a}, 0);
      chk(!rdy_a && !busy_a && !ok_a && !err_a, "R1 flags", {rdy_a, busy_a, ok_a, err_a}, 0);
      chk(tdat_b == 8'hFF && !busy_b, "R1 parallel bus", int'(tdat_b), 255);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk(cfg_a == 0 && !busy_a, "R1 held before start", int'(cfg_a), 0);

      // R2 / R4 / R7 / R11: serial load with fixed-count init
      for (int i = 0; i < 4; i++) tx[i] = 8'($urandom);
      tx[0] = 8'h01;   // LSB-only corner case
      tgt_a = 32;
      pulse_a();
      repeat (15) @(negedge clk);
      chk(cfg_a && busy_a && !rdy_a && !tclk_a, "R2 waits for status", {cfg_a, busy_a, rdy_a, tclk_a}, 4'b1100);
      rel_a = 1;
      for (int i = 0; i < 4; i++) send_a(tx[i], i == 3);
      for (int i = 0; i < 400 && !ok_a; i++) @(negedge clk);
      for (int i = 0; i < 4; i++) chk(rx_a[i] == tx[i], "R4 serial byte LSB first", int'(rx_a[i]), int'(tx[i]));
      chk(init_a == INIC, "R7 init clocks count", init_a, INIC);
      chk(ok_a && !busy_a && !err_a && !tclk_a && tdat_a == 1'b1, "R11 user mode parked",
          {ok_a, busy_a, err_a, tclk_a}, 4'b1000);

      // R11 / R2: reconfiguration request width
      pulse_a();
      lowrun = 0;
      while (!cfg_a && lowrun < 100) begin lowrun++; @(negedge clk); end
      chk(lowrun == LOWC, "R2 request low width", lowrun, LOWC);

      // R8: status drop partway through second byte
      for (int i = 0; i < 4; i++) tx[i] = 8'($urandom);
      send_a(tx[0], 0);
      send_a(tx[1], 0);
      while (bits_a != 11) @(negedge clk);
      rel_a = 0;
      @(negedge clk);
      @(negedge clk);
      chk(!cfg_a && err_a && code_a == 2'd3 && busy_a, "R8 restart on status drop",
          {cfg_a, err_a, code_a}, 5'b0_1_11);
      rel_a = 1;
      for (int i = 0; i < 4; i++) send_a(tx[i], i == 3);
      for (int i = 0; i < 400 && !ok_a; i++) @(negedge clk);
      for (int i = 0; i < 4; i++) chk(rx_a[i] == tx[i], "R8 reload data", int'(rx_a[i]), int'(tx[i]));
      chk(ok_a && !err_a && code_a == 2'd0, "R8 success clears error", {ok_a, err_a, code_a}, 4'b1000);

      // R9: stream ends without done
      tgt_a = 1000;
      pulse_a();
      send_a(8'($urandom), 0);
      send_a(8'hA5, 1);
      wait_a_idle(400);
      chk(!busy_a && err_a && code_a == 2'd2 && !ok_a, "R9 no done at stream end",
          {busy_a, err_a, code_a}, 4'b0110);

      // R10 + R2 ignore: status never rises
      rel_a = 0;
      pulse_a();
      repeat (20) @(negedge clk);
      pulse_a();
      chk(cfg_a && busy_a, "R2 start ignored while busy", int'(cfg_a), 1);
      wait_a_idle(200);
      chk(!busy_a && err_a && code_a == 2'd1, "R10 status timeout", {busy_a, err_a, code_a}, 4'b0101);

      // R6: done seen with a byte still offered
      rel_a = 1;
      tgt_a = 16;
      pulse_a();
      send_a(8'h3C, 0);
      send_a(8'hC3, 0);
      seen_rdy_a = 0;
      val_a = 1; dat_a = 8'h77; last_a = 1;
      for (int i = 0; i < 400 && !ok_a; i++) @(negedge clk);
      chk(!seen_rdy_a, "R6 no byte taken after done", int'(seen_rdy_a), 0);
      chk(ok_a && init_a == INIC, "R6 init follows done", init_a, INIC);
      val_a = 0; last_a = 0;

      // R5 / R7: parallel load with init-done input
      for (int i = 0; i < 3; i++) txb[i] = 8'($urandom);
      tgt_b = 3;
      start_b = 1; @(negedge clk); start_b = 0;
      rel_b = 1;
      for (int i = 0; i < 3; i++) send_b(txb[i], i == 2);
      for (int i = 0; i < 400 && !ok_b; i++) @(negedge clk);
      for (int i = 0; i < 3; i++) chk(rx_b[i] == txb[i], "R5 parallel byte", int'(rx_b[i]), int'(txb[i]));
      chk(bits_b == 3, "R5 one edge per byte", bits_b, 3);
      chk(init_b == 4 && ok_b && tdat_b == 8'hFF, "R7 init-done input", init_b, 4);

      summary();
   end
endmodule